// File: doc/BRIEF.md
# Single-Cycle Token CRC5 Generator and Checker

This block produces and verifies the 5-bit CRC that guards the 11-bit address-plus-endpoint field of a USB token packet. A shift-register CRC would spend eleven clocks on the field. This unit unrolls those eleven shifts into combinational logic instead, so the whole field is absorbed in the clock where it is strobed. The remainder is captured in a register, and the CRC to transmit is the ones' complement of that register.

Checking uses the same unrolled structure. The five received CRC bits are pushed through five more unrolled shifts after the field. A token that arrived intact always leaves the constant remainder 01100. The pass flag therefore comes from one 5-bit compare against a constant, not from comparing against a recomputed CRC. Both results are produced on every strobe. A transmitter ignores the pass flag, and a receiver reads it.

Top module: `tokcrc5_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the remainder register is loaded with 11111. After that edge `crc_o` reads 00000, and `pass_o` and `out_vld_o` read 0. Reset takes priority over a simultaneous `vld_i`.
- R2: Field bit `fld_i[0]` is the first bit on the wire and `fld_i[10]` the last. The address occupies `fld_i[6:0]` (LSB first) and the endpoint occupies `fld_i[10:7]` (LSB first).
- R3: The captured remainder equals the result of eleven serial steps from 11111, applied in wire order. In each step fb = bit ^ r[4], and the next value is {r[3], r[2], r[1]^fb, r[0], fb}, which is the polynomial x^5 + x^2 + 1.
- R4: `crc_o` is the bitwise complement of the captured remainder. `crc_o[4]` is the first CRC bit sent on the wire.
- R5: `crc_o`, `pass_o` and `out_vld_o` change exactly one rising edge after `vld_i` is sampled high. `out_vld_o` is high for exactly the cycle after each sampled strobe, and back-to-back strobes are accepted.
- R6: `rx_crc_i` is applied after the field, `rx_crc_i[4]` first. `pass_o` is 1 only when the remainder after all 16 bits is 01100. This means it is 1 exactly when `rx_crc_i` equals the CRC of the field.
- R7: Flipping any single bit of the 11 field bits or of the 5 received CRC bits of a valid token makes `pass_o` 0.
- R8: With `vld_i` low, `crc_o` and `pass_o` keep their values whatever `fld_i` and `rx_crc_i` do, and `out_vld_o` is 0.
- R9: The field {endpoint 0xE, address 0x15} yields CRC 10111. The field {0xA, 0x3A} yields 11100. The field {0x4, 0x70} yields 01110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Strobe: field and received CRC are valid this cycle |
| fld_i | input | 11 | Token field, bit 0 first on the wire |
| rx_crc_i | input | 5 | Received CRC, bit 4 first on the wire |
| out_vld_o | output | 1 | Results updated by the previous cycle's strobe |
| crc_o | output | 5 | CRC to transmit for the last strobed field |
| pass_o | output | 1 | Last strobed token carried a correct CRC |

## Verification
The bench sweeps all 2048 field values against a bit-serial model. A wrong feedback tap, a field fed in reverse order, or a missing complement would each produce CRCs that differ from the model for most fields and from the three known vectors. Single-bit corruptions of every field and CRC position on a spread of tokens target a checker that feeds the received CRC LSB first or compares against the wrong residue; such a checker passes bad tokens or rejects good ones. All 32 received-CRC values for one field must give exactly one pass. Back-to-back strobes, idle cycles with moving inputs, and a reset that collides with a strobe expose off-by-one latency, results that are not held, and reset that loses to the load.

// File: rtl/tokcrc5_pkg.sv
package tokcrc5_pkg;
  // Token field and CRC widths.
  localparam int TOK_FLD_W = 11;
  localparam int TOK_CRC_W = 5;
  // Feedback taps of x^5 + x^2 + 1 (x^5 implied).
  localparam logic [TOK_CRC_W-1:0] TOK_POLY  = 5'b00101;
  // Preset and the remainder left by an intact field+CRC.
  localparam logic [TOK_CRC_W-1:0] TOK_SEED  = '1;
  localparam logic [TOK_CRC_W-1:0] TOK_RESID = 5'b01100;
endpackage

// File: rtl/tokcrc5_fold.sv
// Unrolled serial CRC: N shift steps in one combinational pass.
// bits_i[0] is absorbed first.
module tokcrc5_fold #(
  parameter int W = 5,
  parameter int N = 11,
  parameter logic [W-1:0] POLY = 5'b00101
) (
  input  logic [W-1:0] seed_i,
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] chain [0:N];

  assign chain[0] = seed_i;

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic fb;
    assign fb           = bits_i[k] ^ chain[k][W-1];
    assign chain[k+1]   = {chain[k][W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign rem_o = chain[N];
endmodule

// File: rtl/tokcrc5_outreg.sv
// Result register: remainder and pass flag, loaded on strobe.
module tokcrc5_outreg #(
  parameter int W = 5,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] rem_d,
  input  logic         pass_d,
  output logic [W-1:0] rem_q,
  output logic         pass_q,
  output logic         vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= SEED;
      pass_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= load_i;
      if (load_i) begin
        rem_q  <= rem_d;
        pass_q <= pass_d;
      end
    end
  end
endmodule

// File: rtl/tokcrc5_unit.sv
module tokcrc5_unit
  import tokcrc5_pkg::*;
#(
  parameter int FLD_W = TOK_FLD_W,
  parameter int CRC_W = TOK_CRC_W,
  parameter logic [CRC_W-1:0] POLY  = TOK_POLY,
  parameter logic [CRC_W-1:0] SEED  = TOK_SEED,
  parameter logic [CRC_W-1:0] RESID = TOK_RESID
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [FLD_W-1:0] fld_i,
  input  logic [CRC_W-1:0] rx_crc_i,
  output logic             out_vld_o,
  output logic [CRC_W-1:0] crc_o,
  output logic             pass_o
);
  logic [CRC_W-1:0] rem_fld;
  logic [CRC_W-1:0] rem_all;
  logic [CRC_W-1:0] rx_wire;
  logic [CRC_W-1:0] rem_q;

  // Received CRC goes MSB first on the wire: reorder so bit 0 is absorbed first.
  always_comb begin
    for (int j = 0; j < CRC_W; j++) rx_wire[j] = rx_crc_i[CRC_W-1-j];
  end

  tokcrc5_fold #(.W(CRC_W), .N(FLD_W), .POLY(POLY)) u_fold_fld (
    .seed_i (SEED),
    .bits_i (fld_i),
    .rem_o  (rem_fld)
  );

  tokcrc5_fold #(.W(CRC_W), .N(CRC_W), .POLY(POLY)) u_fold_rx (
    .seed_i (rem_fld),
    .bits_i (rx_wire),
    .rem_o  (rem_all)
  );

  tokcrc5_outreg #(.W(CRC_W), .SEED(SEED)) u_outreg (
    .clk    (clk),
    .rst    (rst),
    .load_i (vld_i),
    .rem_d  (rem_fld),
    .pass_d (rem_all == RESID),
    .rem_q  (rem_q),
    .pass_q (pass_o),
    .vld_q  (out_vld_o)
  );

  assign crc_o = ~rem_q;
endmodule

// File: rtl/tokcrc5_chk.sv
module tokcrc5_chk #(
  parameter int CRC_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             vld_i,
  input logic [CRC_W-1:0] rx_crc_i,
  input logic             out_vld_o,
  input logic [CRC_W-1:0] crc_o,
  input logic             pass_o
);
  // R1: the cycle after a reset edge shows the reset state.
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (crc_o == '0 && !pass_o && !out_vld_o));

  // R5: a sampled strobe gives a valid result on the next edge.
  p_strobe_lat_r5: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> out_vld_o);

  // R8: no strobe, no change, no valid.
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> (!out_vld_o && $stable(crc_o) && $stable(pass_o)));

  // R6: a received CRC equal to the generated one must pass.
  p_match_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (out_vld_o && crc_o == $past(rx_crc_i)) |-> pass_o);

  // R7: a received CRC differing from the generated one must fail.
  p_mismatch_fail_r7: assert property (@(posedge clk) disable iff (rst)
    (out_vld_o && crc_o != $past(rx_crc_i)) |-> !pass_o);
endmodule

bind tokcrc5_unit tokcrc5_chk #(.CRC_W(CRC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .vld_i     (vld_i),
  .rx_crc_i  (rx_crc_i),
  .out_vld_o (out_vld_o),
  .crc_o     (crc_o),
  .pass_o    (pass_o)
);

// File: tb/tokcrc5_unit_bench.sv
`timescale 1ns/1ps
module tokcrc5_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld = 1'b0;
  logic [10:0] fld = '0;
  logic [4:0]  rx  = '0;
  logic        out_vld;
  logic [4:0]  crc;
  logic        pass;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tokcrc5_unit u_tokcrc5_unit (
    .clk(clk), .rst(rst), .vld_i(vld), .fld_i(fld), .rx_crc_i(rx),
    .out_vld_o(out_vld), .crc_o(crc), .pass_o(pass)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bit-serial reference, written from the step equations of R3.
  function automatic logic [4:0] ser_step(input logic [4:0] r, input logic d);
    logic f;
    f = d ^ r[4];
    return {r[3], r[2], r[1] ^ f, r[0], f};
  endfunction

  function automatic logic [4:0] ref_rem(input logic [10:0] f);
    logic [4:0] r = 5'b11111;
    for (int i = 0; i < 11; i++) r = ser_step(r, f[i]);
    return r;
  endfunction

  function automatic logic [4:0] ref_crc(input logic [10:0] f);
    return ~ref_rem(f);
  endfunction

  function automatic bit ref_pass(input logic [10:0] f, input logic [4:0] c);
    logic [4:0] r = ref_rem(f);
    for (int j = 4; j >= 0; j--) r = ser_step(r, c[j]);
    return (r == 5'b01100);
  endfunction

  // One strobe; returns at the next falling edge with results visible.
  task automatic strobe(input logic [10:0] f, input logic [4:0] c);
    @(negedge clk);
    vld = 1'b1; fld = f; rx = c;
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    logic [4:0] held_crc;
    logic       held_pass;
    int         n_pass;

    repeat (3) @(negedge clk);
    check(crc == 5'b0 && !pass && !out_vld, "R1 reset state", {crc, pass, out_vld}, 0);
    rst = 1'b0;

    // R9 known tokens, field packed as R2 describes
    strobe({4'hE, 7'h15}, 5'b10111);
    check(crc == 5'b10111, "R9 addr15 ep E crc", crc, 5'b10111);
    check(pass, "R9 addr15 ep E pass", pass, 1);
    strobe({4'hA, 7'h3A}, 5'b11100);
    check(crc == 5'b11100, "R9 addr3A ep A crc", crc, 5'b11100);
    strobe({4'h4, 7'h70}, 5'b01110);
    check(crc == 5'b01110, "R9 addr70 ep 4 crc", crc, 5'b01110);

    // R2 R3 R4 R5 R6: every field value, correct CRC returned
    for (int f = 0; f < 2048; f++) begin
      logic [4:0] e;
      e = ref_crc(f[10:0]);
      strobe(f[10:0], e);
      check(crc == e, "R3 R4 sweep crc", crc, e);
      check(pass, "R6 sweep pass", pass, 1);
      check(out_vld, "R5 sweep valid", out_vld, 1);
    end

    // R7: single-bit corruptions of field or CRC
    for (int f = 0; f < 2048; f += 37) begin
      logic [4:0] e;
      e = ref_crc(f[10:0]);
      for (int b = 0; b < 16; b++) begin
        if (b < 11) strobe(f[10:0] ^ (11'd1 << b), e);
        else        strobe(f[10:0], e ^ (5'd1 << (b - 11)));
        check(!pass, "R7 corrupted token", pass, 0);
      end
    end

    // R6: all received values for one field, exactly one passes
    n_pass = 0;
    for (int c = 0; c < 32; c++) begin
      strobe(11'h123, c[4:0]);
      check(pass == ref_pass(11'h123, c[4:0]), "R6 rx sweep", pass, ref_pass(11'h123, c[4:0]));
      if (pass) n_pass++;
    end
    check(n_pass == 1, "R6 single pass", n_pass, 1);

    // R5: back-to-back strobes
    @(negedge clk);
    vld = 1'b1; fld = 11'h5A5; rx = ref_crc(11'h5A5);
    @(negedge clk);
    check(out_vld && crc == ref_crc(11'h5A5), "R5 first of pair", crc, ref_crc(11'h5A5));
    fld = 11'h0F0; rx = 5'b0;
    @(negedge clk);
    vld = 1'b0;
    check(out_vld && crc == ref_crc(11'h0F0), "R5 second of pair", crc, ref_crc(11'h0F0));
    check(pass == ref_pass(11'h0F0, 5'b0), "R6 second of pair", pass, ref_pass(11'h0F0, 5'b0));

    // R8: idle cycles with moving inputs
    held_crc  = crc;
    held_pass = pass;
    for (int k = 0; k < 6; k++) begin
      fld = 11'($urandom);
      rx  = 5'($urandom);
      @(negedge clk);
      check(!out_vld, "R8 idle valid low", out_vld, 0);
      check(crc == held_crc && pass == held_pass, "R8 idle hold",
            {crc, pass}, {held_crc, held_pass});
    end

    // R1: reset colliding with a strobe
    strobe({4'hE, 7'h15}, 5'b10111);
    @(negedge clk);
    rst = 1'b1; vld = 1'b1; fld = 11'h7FF; rx = ref_crc(11'h7FF);
    @(negedge clk);
    rst = 1'b0; vld = 1'b0;
    check(crc == 5'b0 && !pass && !out_vld, "R1 reset over strobe", {crc, pass, out_vld}, 0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule